// File: doc/BRIEF.md
# Keyed Storage Protection Checker

This block decides, for every memory reference, whether the running program may touch the addressed storage. Memory is split into banks of 2048 bytes, and each bank has its own small key register inside the block. A reference carries an 18-bit byte address and the 3-bit key of the current status word. Key 0 belongs to the executive and may reach any bank. Key 1 is the problem program and keys 2 to 7 are user keys. Any nonzero key is admitted only when it equals the key held for the addressed bank. When the keys differ, the block refuses the access and raises a storage-protection fault for the interrupt logic, with program/machine check code 6.

Bank keys are loaded through a set-key port. That port obeys the write only in supervisor mode, where the problem/supervisor bit is 0. A key write tried in problem mode leaves every key unchanged and raises a privileged-operation fault (code 5) in its place. All verdicts are registered and appear in the cycle after the request. The memory array and the interrupt sequencing sit outside this block.

Top module: `keyprot_checker`

## Requirements
- R1: After reset every output is 0 and every bank key register is 0, so a nonzero key is refused in every bank until that bank is written.
- R2: A result appears in the cycle after `req_vld` is sampled high: exactly one of `grant` and `prot_fault` is 1. In the cycle after `req_vld` is sampled low, both are 0.
- R3: A request whose `cur_key` is 0 is granted whatever key the addressed bank holds.
- R4: A request with a nonzero `cur_key` is granted only if that key equals the key register of bank `req_addr[17:11]`. Otherwise it is refused.
- R5: A refused request sets `prot_fault` and puts the value 6 on `fault_code`.
- R6: When `kw_en` is 1 and `prob_mode` is 0, `kw_key` is loaded into the key register of bank `kw_addr[17:11]`. Requests made from the following cycle onward check against the new key.
- R7: When `kw_en` is 1 and `prob_mode` is 1, no key changes. In the next cycle `priv_fault` is 1, and `fault_code` is 5 unless a protection fault occurs in the same cycle.
- R8: A request in the same cycle as a key write to its bank is checked against the key held before that write.
- R9: When a protection fault and a privileged-operation fault are reported in the same cycle, both flags are 1 and `fault_code` is 6.
- R10: A key write changes only the addressed bank. All other banks keep their keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Memory reference strobe |
| req_addr | input | 18 | Byte address of the reference |
| cur_key | input | 3 | Key field of the current status word |
| prob_mode | input | 1 | 1 = problem mode, 0 = supervisor mode |
| kw_en | input | 1 | Set-key request |
| kw_addr | input | 18 | Address selecting the bank whose key is set |
| kw_key | input | 3 | Key value to load |
| grant | output | 1 | Reference admitted (one cycle after the request) |
| prot_fault | output | 1 | Reference refused: storage-protection fault |
| priv_fault | output | 1 | Set-key refused in problem mode |
| fault_code | output | 16 | Program/machine check code: 6 protection, 5 privileged operation, else 0 |

## Verification
A bank register holding a wrong key stays invisible until a nonzero key addresses that bank. Then it shows up one cycle later as a flipped grant or a spurious fault, so the stimulus writes distinct keys into the lowest, a middle and the highest bank and reads each one back with matching and differing keys. A key write that is lost, lands in a neighbouring bank or gets through in problem mode surfaces on the first later reference to that bank or to its neighbour. The bench therefore probes both sides of every write. The ordering of a write against a read in the same cycle and the code priority between two faults show up at the ports only in that single cycle, so each has a directed test.

// File: rtl/keyprot_pkg.sv
package keyprot_pkg;

   localparam int unsigned CODE_W = 16;

   // Program/machine check codes driven on fault_code
   localparam logic [CODE_W-1:0] CODE_NONE = 16'd0;
   localparam logic [CODE_W-1:0] CODE_PRIV = 16'd5;
   localparam logic [CODE_W-1:0] CODE_PROT = 16'd6;

   typedef enum logic [1:0] {
      VERDICT_IDLE  = 2'd0,
      VERDICT_GRANT = 2'd1,
      VERDICT_DENY  = 2'd2
   } verdict_e;

endpackage

// File: rtl/keyprot_keyfile.sv
module keyprot_keyfile #(
   parameter int unsigned NUM_BANKS = 128,
   parameter int unsigned KEY_W     = 3,
   localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] wr_bank,
   input  logic [KEY_W-1:0]  wr_key,
   input  logic [BANK_W-1:0] rd_bank,
   output logic [KEY_W-1:0]  rd_key
);

   logic [KEY_W-1:0] key_q [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n)
            key_q[b] <= '0;
         else if (wr_en && (wr_bank == BANK_W'(b)))
            key_q[b] <= wr_key;
      end
   end

   // Read returns the value held before any write in this cycle
   assign rd_key = key_q[rd_bank];

   AST_KEY_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> key_q[$past(wr_bank)] == $past(wr_key)); // R6

endmodule

// File: rtl/keyprot_decide.sv
module keyprot_decide #(
   parameter int unsigned KEY_W    = 3,
   parameter bit          KEY0_ALL = 1'b1
) (
   input  logic             req_vld,
   input  logic [KEY_W-1:0] cur_key,
   input  logic [KEY_W-1:0] bank_key,
   output keyprot_pkg::verdict_e verdict
);
   import keyprot_pkg::*;

   logic key_match;
   logic bypass;

   assign key_match = (cur_key == bank_key);

   if (KEY0_ALL) begin : g_master
      assign bypass = (cur_key == '0);
   end else begin : g_strict
      assign bypass = 1'b0;
   end

   always_comb begin
      if (!req_vld)
         verdict = VERDICT_IDLE;
      else if (bypass || key_match)
         verdict = VERDICT_GRANT;
      else
         verdict = VERDICT_DENY;
   end

endmodule

// File: rtl/keyprot_checker.sv
module keyprot_checker #(
   parameter int unsigned ADDR_W     = 18,
   parameter int unsigned BANK_BYTES = 2048,
   parameter int unsigned KEY_W      = 3,
   localparam int unsigned CODE_W    = keyprot_pkg::CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [KEY_W-1:0]  cur_key,
   input  logic              prob_mode,
   input  logic              kw_en,
   input  logic [ADDR_W-1:0] kw_addr,
   input  logic [KEY_W-1:0]  kw_key,
   output logic              grant,
   output logic              prot_fault,
   output logic              priv_fault,
   output logic [CODE_W-1:0] fault_code
);
   import keyprot_pkg::*;

   localparam int unsigned OFS_W     = $clog2(BANK_BYTES);
   localparam int unsigned BANK_W    = ADDR_W - OFS_W;
   localparam int unsigned NUM_BANKS = 1 << BANK_W;

   if (BANK_BYTES != (1 << OFS_W)) begin : g_bad_bank
      $error("BANK_BYTES must be a power of two");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W must exceed the bank offset width");
   end
   if (KEY_W < 2) begin : g_bad_key
      $error("KEY_W must be at least 2");
   end

   logic [BANK_W-1:0] rd_bank;
   logic [BANK_W-1:0] wr_bank;
   logic [KEY_W-1:0]  bank_key;
   logic              wr_ok;
   logic              wr_refused;
   verdict_e          verdict;

   assign rd_bank    = req_addr[ADDR_W-1:OFS_W];
   assign wr_bank    = kw_addr[ADDR_W-1:OFS_W];
   assign wr_ok      = kw_en & ~prob_mode;
   assign wr_refused = kw_en & prob_mode;

   keyprot_keyfile #(
      .NUM_BANKS (NUM_BANKS),
      .KEY_W     (KEY_W)
   ) u_keys (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_bank (wr_bank),
      .wr_key  (kw_key),
      .rd_bank (rd_bank),
      .rd_key  (bank_key)
   );

   keyprot_decide #(
      .KEY_W    (KEY_W),
      .KEY0_ALL (1'b1)
   ) u_decide (
      .req_vld  (req_vld),
      .cur_key  (cur_key),
      .bank_key (bank_key),
      .verdict  (verdict)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant      <= 1'b0;
         prot_fault <= 1'b0;
         priv_fault <= 1'b0;
         fault_code <= CODE_NONE;
      end else begin
         grant      <= (verdict == VERDICT_GRANT);
         prot_fault <= (verdict == VERDICT_DENY);
         priv_fault <= wr_refused;
         if (verdict == VERDICT_DENY)
            fault_code <= CODE_PROT;
         else if (wr_refused)
            fault_code <= CODE_PRIV;
         else
            fault_code <= CODE_NONE;
      end
   end

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> (grant != prot_fault)); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> (!grant && !prot_fault)); // R2
   AST_KEY0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && cur_key == '0) |=> grant); // R3
   AST_PROT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      prot_fault |-> fault_code == CODE_PROT); // R5
   AST_PRIV_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (kw_en && prob_mode) |=> priv_fault); // R7
   AST_PRIV_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_fault && !prot_fault) |-> fault_code == CODE_PRIV); // R7

endmodule

// File: tb/sim_keyprot_checker.sv
module sim_keyprot_checker;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 18;
   // {is_write, prob_mode, addr[17:0], key[2:0], exp_grant, exp_prot, exp_priv}
   localparam int VW = 26;
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b0, 1'b1, 18'h00000, 3'd1, 3'b010},  // R1/R4 bank0 still 0
      {1'b0, 1'b0, 18'h3FFFF, 3'd0, 3'b100},  // R3 key 0
      {1'b1, 1'b0, 18'h02800, 3'd3, 3'b000},  // R6 bank5 <- 3
      {1'b0, 1'b1, 18'h02FFF, 3'd3, 3'b100},  // R4 match
      {1'b0, 1'b1, 18'h03000, 3'd3, 3'b010},  // R10 bank6 untouched
      {1'b0, 1'b1, 18'h02800, 3'd2, 3'b010},  // R4 mismatch
      {1'b1, 1'b1, 18'h02800, 3'd2, 3'b001},  // R7 refused
      {1'b0, 1'b1, 18'h02ABC, 3'd3, 3'b100},  // R7 key kept
      {1'b0, 1'b1, 18'h02ABC, 3'd2, 3'b010},  // R7 key kept
      {1'b1, 1'b0, 18'h3F800, 3'd7, 3'b000},  // R6 bank127 <- 7
      {1'b0, 1'b1, 18'h3FFFF, 3'd7, 3'b100},  // R4
      {1'b0, 1'b1, 18'h3F800, 3'd1, 3'b010},  // R4
      {1'b1, 1'b0, 18'h00123, 3'd1, 3'b000},  // R6 bank0 <- 1
      {1'b0, 1'b1, 18'h007FF, 3'd1, 3'b100},  // R4
      {1'b0, 1'b1, 18'h00800, 3'd1, 3'b010},  // R10 bank1 still 0
      {1'b0, 1'b0, 18'h02800, 3'd0, 3'b100},  // R3 bypass
      {1'b1, 1'b0, 18'h02800, 3'd0, 3'b000},  // R6 bank5 <- 0
      {1'b0, 1'b1, 18'h02800, 3'd3, 3'b010}   // R6 new key used
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_vld;
   logic [17:0] req_addr;
   logic [2:0]  cur_key;
   logic        prob_mode;
   logic        kw_en;
   logic [17:0] kw_addr;
   logic [2:0]  kw_key;
   logic        grant;
   logic        prot_fault;
   logic        priv_fault;
   logic [15:0] fault_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   keyprot_checker u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_vld    (req_vld),
      .req_addr   (req_addr),
      .cur_key    (cur_key),
      .prob_mode  (prob_mode),
      .kw_en      (kw_en),
      .kw_addr    (kw_addr),
      .kw_key     (kw_key),
      .grant      (grant),
      .prot_fault (prot_fault),
      .priv_fault (priv_fault),
      .fault_code (fault_code)
   );

   task automatic chk(input string tag, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
      end
   endtask

   task automatic chk_out(input string tag, input bit eg, input bit ep, input bit ev);
      int ec;
      ec = ep ? 6 : (ev ? 5 : 0);
      chk(tag, "grant", int'(grant), int'(eg));
      chk(tag, "prot_fault", int'(prot_fault), int'(ep));
      chk(tag, "priv_fault", int'(priv_fault), int'(ev));
      chk(tag, "fault_code", int'(fault_code), ec);
   endtask

   task automatic idle();
      req_vld = 1'b0; kw_en = 1'b0; prob_mode = 1'b1;
      req_addr = '0; cur_key = '0; kw_addr = '0; kw_key = '0;
   endtask

   // Drive at negedge, let one posedge register, sample at next negedge
   task automatic step();
      @(negedge clk);
   endtask

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      chk_out("R1", 1'b0, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         string tag;
         v = VEC[i];
         idle();
         prob_mode = v[24];
         if (v[25]) begin
            kw_en = 1'b1; kw_addr = v[23:6]; kw_key = v[5:3];
            tag = v[24] ? "R7" : "R6";
         end else begin
            req_vld = 1'b1; req_addr = v[23:6]; cur_key = v[5:3];
            tag = (v[5:3] == 3'd0) ? "R3" : "R4";
         end
         step();
         chk_out(tag, v[2], v[1], v[0]);
         if (v[1]) chk("R5", "fault_code", int'(fault_code), 6);
      end

      // R2: idle cycle gives no verdict
      idle();
      step();
      chk_out("R2", 1'b0, 1'b0, 1'b0);

      // R8: write bank9 <- 4 and request with key 4 in the same cycle
      idle();
      prob_mode = 1'b0; kw_en = 1'b1; kw_addr = 18'h04800; kw_key = 3'd4;
      req_vld = 1'b1; req_addr = 18'h04900; cur_key = 3'd4;
      step();
      chk_out("R8", 1'b0, 1'b1, 1'b0);
      idle();
      req_vld = 1'b1; req_addr = 18'h04900; cur_key = 3'd4;
      step();
      chk_out("R8", 1'b1, 1'b0, 1'b0);

      // R9: refused write together with a refused request
      idle();
      kw_en = 1'b1; kw_addr = 18'h04800; kw_key = 3'd2;
      req_vld = 1'b1; req_addr = 18'h04800; cur_key = 3'd5;
      step();
      chk_out("R9", 1'b0, 1'b1, 1'b1);
      // refused write did not land: key 4 still admitted (R7)
      idle();
      req_vld = 1'b1; req_addr = 18'h04800; cur_key = 3'd4;
      step();
      chk_out("R7", 1'b1, 1'b0, 1'b0);

      // R1: reset in mid-run clears bank keys
      idle();
      rst_n = 1'b0;
      step();
      chk_out("R1", 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      req_vld = 1'b1; req_addr = 18'h3F800; cur_key = 3'd7;
      step();
      chk_out("R1", 1'b0, 1'b1, 1'b0);
      idle();
      req_vld = 1'b1; req_addr = 18'h04800; cur_key = 3'd4;
      step();
      chk_out("R1", 1'b0, 1'b1, 1'b0);

      idle();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule